// File: doc/BRIEF.md
# PLL Lock and Bandwidth Detector

This block judges the state of a phase-locked loop from two divided clocks: the loop's feedback clock and its reference clock. Both arrive as slow square waves. They are brought into the system clock domain through synchronizers and reduced to one-cycle rising-edge pulses.

The block measures frequency by counting feedback edges inside a window of a fixed number of reference periods. At the end of each window it compares the count against the expected count and takes the absolute difference as the frequency error. Two hysteresis flags are updated from that error, and each flag has its own enter and exit tolerances:

- `lock` tells software whether the loop output may be used.
- `acq` selects the loop-filter bandwidth. 0 means acquisition (wide); 1 means tracking (narrow).

With `auto_mode` low, the filter mode is taken from a software-written bit instead. The lock decision keeps running in that case. Every change of `lock` can raise a sticky interrupt request, which software acknowledges with a one-cycle pulse.

Top module: `pll_lock_bw_detect`

## Requirements
- R1: While reset is active and right after it, `lock` = 0, `irq` = 0 and, with `auto_mode` = 1, `acq` = 0 (acquisition).
- R2: A window ends on every 64th rising edge of `ref_clk`. The error is |N − 64|, where N is the number of `fb_clk` rising edges since the previous window end. An `fb_clk` edge seen in the closing cycle counts toward the closing window. `lock` and the automatic tracking flag change only right after a window end.
- R3: When unlocked, `lock` becomes 1 at a window end whose error is at most 1.
- R4: When locked, `lock` becomes 0 at a window end whose error is greater than 2. With an error of 2 or less it stays 1.
- R5: In automatic mode, `acq` goes from 0 to 1 (tracking) at a window end whose error is at most 2.
- R6: In automatic mode, `acq` returns to 0 only at a window end whose error is greater than 4. Errors of 3 or 4 leave it at 1.
- R7: With `auto_mode` = 0, `acq` equals `acq_wr` in the same cycle. `lock` keeps being updated. The automatic flag keeps being computed in the background and reappears on `acq` once `auto_mode` returns to 1.
- R8: Each change of `lock`, rising or falling, sets `irq` in the same cycle as the change, provided `irq_en` was 1. With `irq_en` = 0 a change leaves `irq` untouched.
- R9: `irq` stays 1 until an `irq_ack` pulse clears it. If a lock change and an acknowledge fall in the same cycle, the set wins.
- R10: The feedback count saturates at 255. Windows with no feedback edges, or with far too many, give a large error and are treated as out of every tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_clk | input | 1 | Divided loop feedback clock (asynchronous) |
| ref_clk | input | 1 | Divided reference clock (asynchronous) |
| auto_mode | input | 1 | 1: filter mode chosen by the detector; 0: by `acq_wr` |
| acq_wr | input | 1 | Software filter-mode value used in manual mode |
| irq_en | input | 1 | Enables the interrupt on lock changes |
| irq_ack | input | 1 | One-cycle pulse that clears `irq` |
| lock | output | 1 | Loop locked flag |
| acq | output | 1 | Filter mode: 0 acquisition, 1 tracking |
| irq | output | 1 | Sticky interrupt request |

## Verification
Two functions can fall in the same cycle: the interrupt being set by a lock change and the interrupt being cleared by an acknowledge. The bench first observes, at the ports, in which idle cycle after a window's last reference edge `lock` changes. It then repeats the same transition twice. In one run the acknowledge pulse is placed on exactly the edge that changes `lock`, and `irq` must read 1 afterwards. In the other run the pulse comes one cycle later, and `irq` must read 0.

// File: rtl/pll_det_pkg.sv
package pll_det_pkg;

  // Absolute distance between a measured edge count and the expected count.
  function automatic int unsigned cnt_err(input int unsigned cnt, input int unsigned expect_cnt);
    if (cnt >= expect_cnt) return cnt - expect_cnt;
    else return expect_cnt - cnt;
  endfunction

  // Saturating increment helper for an edge counter of arbitrary width.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned vmax, input logic en);
    if (en && v < vmax) return v + 1;
    else return v;
  endfunction

endpackage

// File: rtl/pll_edge_sync.sv
module pll_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];
  end

  assign rise_pulse = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/pll_freq_window.sv
module pll_freq_window
  import pll_det_pkg::*;
#(
  parameter int WIN = 64,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_pulse,
  input  logic          fb_pulse,
  output logic          meas_valid,
  output logic [CW-1:0] meas_cnt
);
  localparam int RW    = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int FBMAX = (1 << CW) - 1;

  logic [RW-1:0] ref_cnt;
  logic [CW-1:0] fb_cnt;
  logic [CW-1:0] fb_next;
  logic          win_end;

  assign win_end = ref_pulse && (ref_cnt == RW'(WIN - 1));
  assign fb_next = CW'(sat_inc(int'(fb_cnt), FBMAX, fb_pulse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt    <= '0;
      fb_cnt     <= '0;
      meas_valid <= 1'b0;
      meas_cnt   <= '0;
    end else begin
      meas_valid <= win_end;
      if (win_end) begin
        ref_cnt  <= '0;
        fb_cnt   <= '0;
        meas_cnt <= fb_next;
      end else begin
        if (ref_pulse) ref_cnt <= ref_cnt + RW'(1);
        fb_cnt <= fb_next;
      end
    end
  end
endmodule

// File: rtl/pll_hyst_flag.sv
module pll_hyst_flag #(
  parameter int EW    = 8,
  parameter int ENTER = 1,
  parameter int EXIT  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [EW-1:0] meas_err,
  output logic          flag,
  output logic          flag_chg
);
  localparam logic [EW-1:0] ENTER_V = EW'(ENTER);
  localparam logic [EW-1:0] EXIT_V  = EW'(EXIT);

  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (meas_valid) begin
      if (!flag && meas_err <= ENTER_V)     flag_d = 1'b1;
      else if (flag && meas_err > EXIT_V)   flag_d = 1'b0;
    end
  end

  assign flag_chg = flag_d ^ flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/pll_lock_bw_detect.sv
module pll_lock_bw_detect
  import pll_det_pkg::*;
#(
  parameter int WIN         = 64,
  parameter int LOCK_IN     = 1,
  parameter int UNLOCK_OUT  = 2,
  parameter int TRK_IN      = 2,
  parameter int UNTRK_OUT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_clk,
  input  logic ref_clk,
  input  logic auto_mode,
  input  logic acq_wr,
  input  logic irq_en,
  input  logic irq_ack,
  output logic lock,
  output logic acq,
  output logic irq
);
  localparam int CW = $clog2(4 * WIN);
  localparam int EW = CW;

  // Named internal events, visible to the bound checker.
  logic          ref_pulse;
  logic          fb_pulse;
  logic          meas_valid;
  logic [CW-1:0] meas_cnt;
  logic [EW-1:0] meas_err;
  logic          lock_chg;
  logic          acq_auto;
  logic          acq_chg;
  logic          irq_set;

  pll_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_clk), .rise_pulse(ref_pulse)
  );

  pll_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(fb_clk), .rise_pulse(fb_pulse)
  );

  pll_freq_window #(.WIN(WIN), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .meas_valid(meas_valid), .meas_cnt(meas_cnt)
  );

  assign meas_err = EW'(cnt_err(int'(meas_cnt), WIN));

  pll_hyst_flag #(.EW(EW), .ENTER(LOCK_IN), .EXIT(UNLOCK_OUT)) u_lock (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_err(meas_err),
    .flag(lock), .flag_chg(lock_chg)
  );

  pll_hyst_flag #(.EW(EW), .ENTER(TRK_IN), .EXIT(UNTRK_OUT)) u_trk (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_err(meas_err),
    .flag(acq_auto), .flag_chg(acq_chg)
  );

  assign acq     = auto_mode ? acq_auto : acq_wr;
  assign irq_set = lock_chg & irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_ack) irq <= 1'b0;
  end
endmodule

// File: rtl/pll_det_chk.sv
module pll_det_chk #(
  parameter int EW         = 8,
  parameter int LOCK_IN    = 1,
  parameter int UNLOCK_OUT = 2,
  parameter int TRK_IN     = 2,
  parameter int UNTRK_OUT  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_mode,
  input logic          acq_wr,
  input logic          irq_en,
  input logic          irq_ack,
  input logic          lock,
  input logic          acq,
  input logic          irq,
  input logic          meas_valid,
  input logic [EW-1:0] meas_err,
  input logic          acq_auto
);
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (!lock && !irq && !acq_auto));

  a_r2_change_at_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lock) || !$stable(acq_auto)) |-> $past(meas_valid));

  a_r3_lock_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> int'($past(meas_err)) <= LOCK_IN);

  a_r4_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> int'($past(meas_err)) > UNLOCK_OUT);

  a_r5_track_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_auto) |-> int'($past(meas_err)) <= TRK_IN);

  a_r6_track_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acq_auto) |-> int'($past(meas_err)) > UNTRK_OUT);

  a_r7_manual_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_mode && $past(!auto_mode) && $stable(acq_wr)) |-> $stable(acq));

  a_r8_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lock) && $past(irq_en)) |-> irq);

  a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(irq_ack));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$stable(lock));
endmodule

bind pll_lock_bw_detect pll_det_chk #(
  .EW(EW), .LOCK_IN(LOCK_IN), .UNLOCK_OUT(UNLOCK_OUT),
  .TRK_IN(TRK_IN), .UNTRK_OUT(UNTRK_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .acq_wr(acq_wr),
  .irq_en(irq_en), .irq_ack(irq_ack), .lock(lock), .acq(acq), .irq(irq),
  .meas_valid(meas_valid), .meas_err(meas_err), .acq_auto(acq_auto)
);

// File: tb/sim_pll_lock_bw_detect.sv
`timescale 1ns/1ps
module sim_pll_lock_bw_detect;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, fb_clk, ref_clk, auto_mode, acq_wr, irq_en, irq_ack;
  logic lock, acq, irq;

  pll_lock_bw_detect u0 (
    .clk(clk), .rst_n(rst_n), .fb_clk(fb_clk), .ref_clk(ref_clk),
    .auto_mode(auto_mode), .acq_wr(acq_wr), .irq_en(irq_en), .irq_ack(irq_ack),
    .lock(lock), .acq(acq), .irq(irq)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  // Reference model state
  bit m_lock = 0, m_trk = 0, m_irq = 0;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Thresholds: lock in <=1, unlock >2, track in <=2, untrack >4 (R3..R6)
  task automatic model(input int n);
    int e;
    bit old;
    if (n > 255) n = 255;
    e = (n >= 64) ? n - 64 : 64 - n;
    old = m_lock;
    if (!m_lock && e <= 1) m_lock = 1;
    else if (m_lock && e > 2) m_lock = 0;
    if (!m_trk && e <= 2) m_trk = 1;
    else if (m_trk && e > 4) m_trk = 0;
    if (old != m_lock && irq_en) m_irq = 1;
  endtask

  // One window: 64 reference periods of 8 cycles, n feedback pulses before each ref edge.
  task automatic run_window(input int n, input int ack_at, output int rise_at);
    logic lprev;
    lprev = lock;
    rise_at = -1;
    for (int i = 0; i < 64; i++) begin
      int p;
      p = n / 64 + ((i < n % 64) ? 1 : 0);
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        fb_clk  = ((c % 2) == 0) && ((c / 2) < p);
        ref_clk = (c == 7);
      end
    end
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      fb_clk = 0;
      ref_clk = 0;
      if (rise_at < 0 && lock !== lprev) rise_at = c;
      irq_ack = (c == ack_at);
    end
    @(negedge clk);
    irq_ack = 0;
  endtask

  task automatic win(input int n);
    int r;
    run_window(n, -1, r);
    model(n);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    m_irq = 0;
    @(negedge clk);
    chk("R9 ack clears", irq, 1'b0);
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " lock"}, lock, m_lock);
    chk({tag, " acq"}, acq, auto_mode ? m_trk : acq_wr);
    chk({"R8 irq after ", tag}, irq, m_irq);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int r, rr;
    rst_n = 0; fb_clk = 0; ref_clk = 0; auto_mode = 1; acq_wr = 0; irq_en = 1; irq_ack = 0;
    repeat (4) @(negedge clk);
    chk("R1 lock in reset", lock, 0);
    chk("R1 acq in reset", acq, 0);
    chk("R1 irq in reset", irq, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 lock after reset", lock, 0);
    chk("R1 irq after reset", irq, 0);

    // Sweep deviations from both the locked/tracking and the unlocked state (R2..R6)
    for (int d = -6; d <= 6; d++) begin
      win(64);      chk_all("R3 R5 settle");  ack();
      win(64 + d);  chk_all("R4 R6 from locked");  ack();
      win(84);      chk_all("R4 R6 far");  ack();
      win(64 + d);  chk_all("R3 R5 from unlocked");  ack();
    end

    // Saturation and empty windows (R10)
    win(64);  ack();
    win(0);   chk_all("R10 no feedback");  ack();
    win(64);  ack();
    win(256); chk_all("R10 saturated");  ack();

    // Interrupt disabled (R8)
    irq_en = 0;
    win(64);  chk_all("R8 disabled set");
    win(84);  chk_all("R8 disabled clear");
    irq_en = 1;

    // Manual mode (R7)
    win(64); ack();
    @(negedge clk); auto_mode = 0; acq_wr = 1;
    @(negedge clk); chk("R7 manual acq=1", acq, 1);
    acq_wr = 0;
    @(negedge clk); chk("R7 manual acq=0", acq, 0);
    acq_wr = 1;
    win(84); chk_all("R7 manual window"); ack();
    chk("R7 manual acq held", acq, 1);
    @(negedge clk); auto_mode = 1;
    @(negedge clk); chk("R7 auto restored", acq, m_trk);

    // Set and acknowledge in the same cycle (R9)
    win(84); ack();
    run_window(64, -1, r); model(64); ack();
    win(84); ack();
    run_window(64, r - 1, rr); model(64);
    chk("R9 set wins over ack", irq, 1);
    chk("R9 lock rose", lock, 1);
    ack();
    win(84); ack();
    run_window(64, r, rr); model(64); m_irq = 0;
    chk("R9 later ack clears", irq, 0);
    chk("R9 lock rose again", lock, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule